// File: doc/BRIEF.md
# Word-Clock-Aligned I2S Clock Divider

This block lives in the master clock domain of an audio converter. An external PLL derives the master clock from a word clock, at 2^CNT_W (512) master cycles per sample. The block divides the master clock down to an I2S bit clock and a left/right frame clock. A free-running divider would settle on an arbitrary one of the 512 possible phases. This block instead uses the word clock as a phase reference, so the frame clock always lands at the same, repeatable offset from the word clock. That offset does not change across power-ups or resyncs, and it is the same on every unit that receives the same reference.

The word clock is synchronized and its rising edge detected. The first edge after reset loads the divider counter with a fixed constant. Each later edge is only compared with the phase the counter is expected to have at that moment. Small jitter on the reference is absorbed. The counter is reloaded only when the reference has really moved, which means several consecutive edges outside a tolerance window. If the reference disappears, the divider keeps running at its last phase and a loss flag is raised.

Top module: `wcsync_clkdiv`

## Requirements
- R1: While reset is high, and in the first cycle after it, bclk_o, lrclk_o, aligned_o, resync_o and ref_lost_o are all 0.
- R2: The first word-clock rise after reset loads the counter with LOAD_VAL. It is acted on three master cycles after the rise is presented (two synchronizer flops plus edge detection), and aligned_o goes high in that same cycle.
- R3: bclk_o is counter bit BCLK_BIT, which gives 64 bit-clock periods of 8 master cycles per frame. lrclk_o is the counter MSB: 0 (left) for counts 0..255 and 1 (right) for counts 256..511.
- R4: Outside a reload, lrclk_o changes only in the cycle where bclk_o falls.
- R5: With LOAD_VAL = 3, lrclk_o rises exactly 256 master cycles after the word-clock rise is presented, whatever the power-up phase.
- R6: A word-clock edge within ±PHASE_TOL master cycles of the expected phase causes no reload. aligned_o stays high and the clocks keep their phase.
- R7: Fewer than MISS_LIMIT consecutive edges outside the window are ignored. There is no reload, no change of aligned_o and no phase change.
- R8: On the MISS_LIMIT-th consecutive out-of-window edge, the counter is reloaded with LOAD_VAL, resync_o pulses for exactly one cycle and aligned_o goes low. The next in-window edge sets aligned_o again.
- R9: If no edge is detected for LOSS_FRAMES×512 master cycles, ref_lost_o goes high and aligned_o goes low. The divider keeps counting from its last phase.
- R10: A returning edge clears ref_lost_o at the same three-cycle latency, and it sets aligned_o when it lies within the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master (modulator) clock, 512× the word rate |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock reference, asynchronous |
| bclk_o | output | 1 | I2S bit clock |
| lrclk_o | output | 1 | I2S left/right frame clock |
| aligned_o | output | 1 | Divider phase agrees with the reference |
| resync_o | output | 1 | One-cycle pulse on a realignment reload |
| ref_lost_o | output | 1 | No reference edge for LOSS_FRAMES frames |

## Verification
The bench uses the default configuration: a 9-bit counter, LOAD_VAL 3, PHASE_TOL 2, MISS_LIMIT 4 and LOSS_FRAMES 2. A 512-cycle frame keeps each scenario to a few thousand cycles. This makes it possible to sweep sixteen power-up phases spread across the whole frame, and to compare every output cycle against the counter value predicted from the time of the reference edge. The small tolerance and miss limit bring the window boundary (±2 against ±3) and the three-versus-four consecutive-miss threshold within reach. The two-frame loss limit allows the flag to be checked one cycle before and one cycle after it trips, and the divider to be followed through a loss and back.

// File: rtl/wcsync_pkg.sv
package wcsync_pkg;

    // Divider tracking state
    typedef enum logic [0:0] {
        ST_ACQUIRE = 1'b0,
        ST_TRACK   = 1'b1
    } track_state_e;

    // Classification of a detected reference edge
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_MATCH = 2'd1,
        EV_MISS  = 2'd2
    } edge_class_e;

    // Status bundle carried to the top-level outputs
    typedef struct packed {
        logic aligned;
        logic resync;
        logic ref_lost;
    } sync_status_t;

    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Magnitude of a two's-complement phase error held in the low w bits
    function automatic logic [31:0] err_magnitude(input logic [31:0] err, input int unsigned w);
        logic [31:0] mask;
        logic [31:0] v;
        mask = (32'd1 << w) - 32'd1;
        v    = err & mask;
        if (v[w-1])
            return ((~v) + 32'd1) & mask;
        return v;
    endfunction

endpackage

// File: rtl/wcsync_edge.sv
module wcsync_edge #(
    parameter int unsigned SYNC_STAGES = wcsync_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic wclk_in,
    output logic rise
);
    // pipe[0..SYNC_STAGES-1]: synchronizer, pipe[SYNC_STAGES]: history flop
    logic [SYNC_STAGES:0] pipe;

    generate
        for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= 1'b0;
                    else     pipe[0] <= wclk_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= 1'b0;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

endmodule

// File: rtl/wcsync_divider.sv
module wcsync_divider #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned BCLK_BIT = 2,
    parameter int unsigned LOAD_VAL = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic             bclk,
    output logic             lrclk
);
    localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(LOAD_VAL);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= LOAD_C;
        else           cnt <= cnt + 1'b1;
    end

    // Both taps come from one register, so the MSB toggles only when the
    // lower bits wrap, which is also a falling transition of the BCLK tap.
    assign bclk  = cnt[BCLK_BIT];
    assign lrclk = cnt[CNT_W-1];

endmodule

// File: rtl/wcsync_loss_mon.sv
module wcsync_loss_mon #(
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned LOSS_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    output logic lost_trip,
    output logic ref_lost
);
    localparam int unsigned LOSS_CYC = LOSS_FRAMES << CNT_W;
    localparam int unsigned GAP_W    = $clog2(LOSS_CYC + 1);
    localparam logic [GAP_W-1:0] TRIP_AT = GAP_W'(LOSS_CYC - 1);

    logic [GAP_W-1:0] gap;

    assign lost_trip = !rise && !ref_lost && (gap == TRIP_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= '0;
            ref_lost <= 1'b0;
        end else if (rise) begin
            gap      <= '0;
            ref_lost <= 1'b0;
        end else if (!ref_lost) begin
            gap <= gap + 1'b1;
            if (lost_trip) ref_lost <= 1'b1;
        end
    end

endmodule

// File: rtl/wcsync_phase_ctl.sv
module wcsync_phase_ctl
    import wcsync_pkg::*;
#(
    parameter int unsigned CNT_W      = 9,
    parameter int unsigned LOAD_VAL   = 3,
    parameter int unsigned PHASE_TOL  = 2,
    parameter int unsigned MISS_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             lost_trip,
    input  logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             aligned,
    output logic             resync
);
    localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0]  LOAD_C   = CNT_W'(LOAD_VAL);
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_LIMIT - 1);

    track_state_e      state, state_n;
    edge_class_e       ev;
    logic [MISS_W-1:0] miss_cnt, miss_cnt_n;
    logic              aligned_n, resync_n;
    logic [CNT_W-1:0]  phase_err;
    logic [31:0]       err_mag;

    // Error of the counter's next value against the load constant
    assign phase_err = cnt + 1'b1 - LOAD_C;
    assign err_mag   = err_magnitude(32'(phase_err), CNT_W);

    always_comb begin
        if (!rise)                      ev = EV_NONE;
        else if (err_mag <= PHASE_TOL)  ev = EV_MATCH;
        else                            ev = EV_MISS;
    end

    always_comb begin
        state_n    = state;
        miss_cnt_n = miss_cnt;
        aligned_n  = aligned;
        resync_n   = 1'b0;
        load       = 1'b0;
        if (state == ST_ACQUIRE) begin
            if (ev != EV_NONE) begin
                load       = 1'b1;
                state_n    = ST_TRACK;
                aligned_n  = 1'b1;
                miss_cnt_n = '0;
            end
        end else begin
            unique case (ev)
                EV_MATCH: begin
                    miss_cnt_n = '0;
                    aligned_n  = 1'b1;
                end
                EV_MISS: begin
                    if (miss_cnt == MISS_TOP) begin
                        load       = 1'b1;
                        resync_n   = 1'b1;
                        aligned_n  = 1'b0;
                        miss_cnt_n = '0;
                    end else begin
                        miss_cnt_n = miss_cnt + 1'b1;
                    end
                end
                default: begin
                    if (lost_trip) begin
                        aligned_n  = 1'b0;
                        miss_cnt_n = '0;
                    end
                end
            endcase
        end
        if (state == ST_ACQUIRE && ev == EV_NONE && lost_trip)
            aligned_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_ACQUIRE;
            miss_cnt <= '0;
            aligned  <= 1'b0;
            resync   <= 1'b0;
        end else begin
            state    <= state_n;
            miss_cnt <= miss_cnt_n;
            aligned  <= aligned_n;
            resync   <= resync_n;
        end
    end

endmodule

// File: rtl/wcsync_clkdiv.sv
module wcsync_clkdiv
    import wcsync_pkg::*;
#(
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned BCLK_BIT    = 2,
    parameter int unsigned LOAD_VAL    = 3,
    parameter int unsigned PHASE_TOL   = 2,
    parameter int unsigned MISS_LIMIT  = 4,
    parameter int unsigned LOSS_FRAMES = 2,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic wclk_in,
    output logic bclk_o,
    output logic lrclk_o,
    output logic aligned_o,
    output logic resync_o,
    output logic ref_lost_o
);
    logic             ref_rise;
    logic             lost_trip;
    logic             div_load;
    logic [CNT_W-1:0] div_cnt;
    sync_status_t     status;

    wcsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .wclk_in (wclk_in),
        .rise    (ref_rise)
    );

    wcsync_loss_mon #(.CNT_W(CNT_W), .LOSS_FRAMES(LOSS_FRAMES)) u_loss (
        .clk       (clk),
        .rst       (rst),
        .rise      (ref_rise),
        .lost_trip (lost_trip),
        .ref_lost  (status.ref_lost)
    );

    wcsync_phase_ctl #(
        .CNT_W      (CNT_W),
        .LOAD_VAL   (LOAD_VAL),
        .PHASE_TOL  (PHASE_TOL),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .rise      (ref_rise),
        .lost_trip (lost_trip),
        .cnt       (div_cnt),
        .load      (div_load),
        .aligned   (status.aligned),
        .resync    (status.resync)
    );

    wcsync_divider #(.CNT_W(CNT_W), .BCLK_BIT(BCLK_BIT), .LOAD_VAL(LOAD_VAL)) u_div (
        .clk   (clk),
        .rst   (rst),
        .load  (div_load),
        .cnt   (div_cnt),
        .bclk  (bclk_o),
        .lrclk (lrclk_o)
    );

    assign aligned_o  = status.aligned;
    assign resync_o   = status.resync;
    assign ref_lost_o = status.ref_lost;

endmodule

// File: rtl/wcsync_checker.sv
module wcsync_checker #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned LOAD_VAL = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             bclk,
    input logic             lrclk,
    input logic             aligned,
    input logic             resync,
    input logic             ref_lost,
    input logic             load,
    input logic [CNT_W-1:0] cnt
);
    // R4: frame clock moves only on a bit-clock falling edge unless reloaded
    p_lr_on_bclk_fall_r4: assert property (@(posedge clk) disable iff (rst)
        ((lrclk != $past(lrclk)) && !$past(load)) |-> ($past(bclk) && !bclk));

    // R8: resync is a single-cycle pulse
    p_resync_single_r8: assert property (@(posedge clk) disable iff (rst)
        resync |=> !resync);

    // R8: a resync reload lands the counter on the load constant and drops aligned
    p_reload_value_r8: assert property (@(posedge clk) disable iff (rst)
        resync |-> (cnt == CNT_W'(LOAD_VAL)) && !aligned);

    // R9: loss of reference and aligned are never both high
    p_lost_not_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        ref_lost |-> !aligned);

    // R9: while the reference stays lost the divider free-runs
    p_free_run_r9: assert property (@(posedge clk) disable iff (rst)
        (ref_lost && $past(ref_lost)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

bind wcsync_clkdiv wcsync_checker #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bclk     (bclk_o),
    .lrclk    (lrclk_o),
    .aligned  (aligned_o),
    .resync   (resync_o),
    .ref_lost (ref_lost_o),
    .load     (div_load),
    .cnt      (div_cnt)
);

// File: tb/wcsync_clkdiv_test.sv
module wcsync_clkdiv_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 9;
    localparam int BIT_B      = 2;
    localparam int LOAD       = 3;
    localparam int TOL        = 2;
    localparam int MISS       = 4;
    localparam int LOSSF      = 2;
    localparam int FRAME      = 1 << CNT_W;
    localparam int HALF       = FRAME / 2;
    localparam int LOSS_CYC   = LOSSF * FRAME;
    localparam int LAT        = 3;
    localparam int LR_DELAY   = HALF - LOAD + LAT;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wclk = 1'b0;
    logic bclk, lrclk, aligned, resync, ref_lost;

    int checks = 0, fails = 0;
    bit done = 0;

    int neg_idx = 0;
    int grid_rise = 0, jit = 0, jit_amt = 0, jit_count = 0, perm_shift = 0;
    bit gen_on = 0;
    int last_rise = 0, rise_count = 0;
    int n0 = 0;
    bit track_on = 0;
    int wave_err = 0, lr_bad = 0, resync_seen = 0, aligned_low = 0;
    int lr_rise_idx = -1;
    logic prev_lr = 1'b0, prev_bclk = 1'b0;

    wcsync_clkdiv #(
        .CNT_W(CNT_W), .BCLK_BIT(BIT_B), .LOAD_VAL(LOAD), .PHASE_TOL(TOL),
        .MISS_LIMIT(MISS), .LOSS_FRAMES(LOSSF), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst(rst), .wclk_in(wclk),
        .bclk_o(bclk), .lrclk_o(lrclk), .aligned_o(aligned),
        .resync_o(resync), .ref_lost_o(ref_lost)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        wave_err = 0; lr_bad = 0; resync_seen = 0; aligned_low = 0;
    endtask

    // One master cycle: sample at the falling edge, then drive the reference
    task automatic step();
        int e, r;
        @(negedge clk);
        neg_idx++;
        if (track_on && neg_idx >= n0 + LAT) begin
            e = (LOAD + neg_idx - n0 - LAT) % FRAME;
            if (lrclk !== (e >= HALF) || bclk !== logic'((e >> BIT_B) & 1))
                wave_err++;
            if (neg_idx >= n0 + LAT + 1 && lrclk !== prev_lr && !(prev_bclk && !bclk))
                lr_bad++;
            if (lrclk && !prev_lr && lr_rise_idx < 0)
                lr_rise_idx = neg_idx;
        end
        if (resync) resync_seen++;
        if (!aligned) aligned_low++;
        prev_lr = lrclk;
        prev_bclk = bclk;
        if (gen_on) begin
            r = grid_rise + jit;
            if (neg_idx == r) begin
                last_rise = neg_idx;
                rise_count++;
            end
            wclk = (neg_idx >= r && neg_idx < r + HALF);
            if (neg_idx == r + HALF - 1) begin
                grid_rise = grid_rise + FRAME + perm_shift;
                perm_shift = 0;
                if (jit_count > 0) begin
                    jit = jit_amt;
                    jit_count--;
                end else jit = 0;
            end
        end else begin
            wclk = 1'b0;
        end
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic wait_until(input int idx);
        while (neg_idx < idx) step();
    endtask

    task automatic wait_rise();
        int b;
        b = rise_count;
        while (rise_count == b) step();
    endtask

    initial begin
        int base, r4, r5, L, k, rr;
        // Phase sweep over power-up positions (R1, R2, R3, R4, R5)
        for (int p = 0; p < 16; p++) begin
            rst = 1'b1; gen_on = 0; track_on = 0;
            run(3);
            check(bclk === 1'b0 && lrclk === 1'b0, "R1", "clocks in reset", {bclk, lrclk}, 0);
            check(aligned === 1'b0 && resync === 1'b0 && ref_lost === 1'b0, "R1", "flags in reset",
                  {aligned, resync, ref_lost}, 0);
            rst = 1'b0;
            if (p == 0) begin
                step();
                check({bclk, lrclk, aligned, resync, ref_lost} === 5'b0, "R1",
                      "outputs first cycle after reset", {bclk, lrclk, aligned, resync, ref_lost}, 0);
            end
            grid_rise = neg_idx + p * 31 + 5;
            jit = 0; jit_count = 0; perm_shift = 0;
            gen_on = 1; n0 = grid_rise; track_on = 1; lr_rise_idx = -1;
            clear_stats();
            wait_until(n0 + LAT - 1);
            check(aligned === 1'b0, "R2", "aligned before first edge acted", aligned, 0);
            step();
            check(aligned === 1'b1, "R2", "aligned on first edge", aligned, 1);
            run(3 * FRAME);
            check(wave_err == 0, "R3", "bclk/lrclk waveform cycles wrong", wave_err, 0);
            check(lr_bad == 0, "R4", "lrclk moves off a bclk fall", lr_bad, 0);
            check(lr_rise_idx - n0 == LR_DELAY, "R5", "lrclk rise offset from reference",
                  lr_rise_idx - n0, LR_DELAY);
            check(resync_seen == 0, "R6", "resync pulses on steady reference", resync_seen, 0);
        end

        // R6: edges jittered by exactly the tolerance
        wait_rise(); run(10);
        clear_stats();
        jit_amt = TOL; jit_count = 1;
        run(2 * FRAME);
        jit_amt = -TOL; jit_count = 1;
        run(2 * FRAME);
        check(wave_err == 0, "R6", "phase moved under in-window jitter", wave_err, 0);
        check(resync_seen == 0, "R6", "resync under in-window jitter", resync_seen, 0);
        check(aligned_low == 0, "R6", "aligned dropped under in-window jitter", aligned_low, 0);

        // R7: MISS-1 consecutive edges just outside the window
        wait_rise(); run(10);
        clear_stats();
        jit_amt = TOL + 1; jit_count = MISS - 1;
        run((MISS + 2) * FRAME);
        check(wave_err == 0, "R7", "phase moved on too few misses", wave_err, 0);
        check(resync_seen == 0, "R7", "resync on too few misses", resync_seen, 0);
        check(aligned_low == 0, "R7", "aligned dropped on too few misses", aligned_low, 0);

        // R8: permanent shift of the reference by 100 cycles
        wait_rise(); run(10);
        perm_shift = 100;
        base = rise_count;
        clear_stats();
        while (rise_count < base + MISS) step();
        r4 = last_rise;
        wait_until(r4 + LAT - 1);
        check(wave_err == 0, "R8", "old phase kept before reload", wave_err, 0);
        check(resync_seen == 0 && aligned_low == 0, "R8", "early reload or aligned drop",
              resync_seen + aligned_low, 0);
        n0 = r4;
        step();
        check(resync === 1'b1, "R8", "resync on the limit edge", resync, 1);
        check(aligned === 1'b0, "R8", "aligned cleared by reload", aligned, 0);
        step();
        check(resync === 1'b0, "R8", "resync width", resync, 0);
        while (rise_count < base + MISS + 1) step();
        r5 = last_rise;
        wait_until(r5 + LAT - 1);
        check(aligned === 1'b0, "R8", "aligned before next matching edge", aligned, 0);
        step();
        check(aligned === 1'b1, "R8", "aligned on next matching edge", aligned, 1);
        clear_stats();
        run(FRAME);
        check(wave_err == 0 && lr_bad == 0, "R8", "waveform after reload", wave_err + lr_bad, 0);

        // R9: loss of reference
        wait_rise();
        L = last_rise;
        run(10);
        gen_on = 0;
        clear_stats();
        wait_until(L + LAT + LOSS_CYC - 1);
        check(ref_lost === 1'b0, "R9", "ref_lost one cycle early", ref_lost, 0);
        check(aligned === 1'b1, "R9", "aligned before loss", aligned, 1);
        step();
        check(ref_lost === 1'b1, "R9", "ref_lost at limit", ref_lost, 1);
        check(aligned === 1'b0, "R9", "aligned cleared on loss", aligned, 0);
        run(2 * FRAME);
        check(wave_err == 0, "R9", "divider not free-running while lost", wave_err, 0);
        check(ref_lost === 1'b1 && resync_seen == 0, "R9", "lost state held", ref_lost, 1);

        // R10: reference returns on the old grid
        k = (neg_idx - L) / FRAME + 1;
        grid_rise = L + k * FRAME;
        jit = 0; jit_count = 0; perm_shift = 0;
        gen_on = 1;
        wait_rise();
        rr = last_rise;
        wait_until(rr + LAT - 1);
        check(ref_lost === 1'b1, "R10", "ref_lost before edge acted", ref_lost, 1);
        step();
        check(ref_lost === 1'b0, "R10", "ref_lost cleared", ref_lost, 0);
        check(aligned === 1'b1, "R10", "aligned restored", aligned, 1);
        clear_stats();
        run(FRAME);
        check(wave_err == 0 && resync_seen == 0, "R10", "phase kept after return",
              wave_err + resync_seen, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule